// File: doc/BRIEF.md
# Endpoint Buffer Window Allocator

This block keeps track of where each endpoint's packet buffer lives inside one shared buffer RAM of a USB-style device controller. The number of endpoints is small and fixed. Software programs each endpoint through a narrow write port. A write selects one endpoint and carries its packet size code, bank count, enable bit and allocate bit. The block keeps a base address and a window size for every endpoint, and the data path reads them from the outputs.

Windows are packed upward in endpoint order. An allocation or release only ever moves the window of the endpoint written and of the endpoint directly above it. Windows further up stay where they are, so a grown window can run into a higher one. The block reports that case with a per-endpoint overlap flag. It also reports a per-endpoint configuration-OK flag, which tells whether the requested geometry was legal when the window was allocated.

All results are registered. They appear one clock after the write.

Top module: `bufwin_alloc`

## Requirements
- R1: Synchronous active-high reset clears every allocate, enable, configuration-OK and overlap flag and sets every base and size output to 0.
- R2: A write (`wr_en`=1) carries the size code in `wr_data[2:0]`, the bank count in `wr_data[4:3]`, the enable bit in `wr_data[5]` and the allocate bit in `wr_data[6]`, and selects the endpoint with `wr_ep`. All outputs change on the clock edge that samples the write and hold while `wr_en`=0. A newly allocated window is (8 << code) × banks bytes.
- R3: A window allocated by writing allocate=1 to an unallocated endpoint n starts at the end (base + size) of the highest-numbered allocated endpoint below n. If no lower endpoint is allocated, it starts at 0.
- R4: A write to an endpoint that is already allocated with allocate=1 only updates its enable output. Its base, size and size/bank fields are left unchanged. Clearing the enable bit does not free the window.
- R5: Writing allocate=0 to an allocated endpoint n frees its window: its allocate and configuration-OK flags clear and its base and size read 0. If endpoint n+1 is allocated, its base moves down to the end of the highest allocated window below n, or to 0 if there is none.
- R6: When endpoint n is allocated while endpoint n+1 is allocated, endpoint n+1's base moves to the new end of endpoint n's window.
- R7: An allocation change of endpoint n moves no window other than those of n and n+1. In particular, endpoint 0 never moves because of another endpoint.
- R8: On allocation, configuration-OK is set only if the size code is at most the endpoint's limit (3 for endpoint 0, 7 otherwise), the bank count is nonzero and at most the limit (1 for endpoint 0, 3 otherwise), and the window ends at or below the RAM size (4096 bytes). An illegal request still allocates the window, with configuration-OK at 0. The flag is never set on an unallocated endpoint.
- R9: An endpoint's overlap flag is 1 exactly when its allocated, non-empty window shares at least one byte with another allocated, non-empty window. Windows that only touch end-to-start do not overlap.
- R10: Writing allocate=0 to an unallocated endpoint changes no base, size or allocate output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_ep | input | EP_W (2) | Endpoint selected by the write |
| wr_data | input | 7 | {allocate, enable, banks[1:0], size code[2:0]} |
| ep_base | output | NUM_EP×AW (60) | Per-endpoint window base, endpoint i at bits [i×AW +: AW] |
| ep_size | output | NUM_EP×AW (60) | Per-endpoint window size in bytes, same packing |
| ep_alloc | output | NUM_EP | Per-endpoint allocate state |
| ep_enable | output | NUM_EP | Per-endpoint enable state |
| ep_cfg_ok | output | NUM_EP | Per-endpoint configuration-OK |
| ep_overlap | output | NUM_EP | Per-endpoint overlap flag |

## Verification
Every cycle, the assertions check these properties:
- Windows away from the written endpoint and its upper neighbour keep their bases.
- A release empties the window.
- A write to an allocated endpoint changes only its enable bit.
- The outputs hold between writes.
- Configuration-OK never stands on an unallocated endpoint.
- The overlap flags come in groups of at least two.

The actual addresses can only be shown by the bench's scenarios. These cover the packing order, the slide-down on release, the push-up on growth, the conflict that then appears, the limit and RAM-fit checks, and the fact that touching windows are not flagged.

// File: rtl/bufwin_pkg.sv
package bufwin_pkg;
  localparam int CFG_W = 7;

  typedef struct packed {
    logic       alloc;
    logic       enable;
    logic [1:0] banks;
    logic [2:0] code;
  } cfg_word_t;
endpackage

// File: rtl/bufwin_size_calc.sv
module bufwin_size_calc #(
  parameter int AW            = 15,
  parameter int EP_W          = 2,
  parameter int RAM_BYTES     = 4096,
  parameter int EP0_MAX_CODE  = 3,
  parameter int EPN_MAX_CODE  = 7,
  parameter int EP0_MAX_BANKS = 1,
  parameter int EPN_MAX_BANKS = 3
) (
  input  logic [EP_W-1:0] ep,
  input  logic [2:0]      code,
  input  logic [1:0]      banks,
  input  logic [AW-1:0]   start,
  output logic [AW-1:0]   win_size,
  output logic            legal
);
  logic [AW-1:0] unit;
  logic [AW:0]   end_sum;
  logic [31:0]   max_c;
  logic [31:0]   max_b;

  always_comb begin
    unit     = AW'(8) << code;
    win_size = unit * AW'(banks);
    end_sum  = {1'b0, start} + {1'b0, win_size};
    max_c    = (ep == '0) ? 32'(EP0_MAX_CODE)  : 32'(EPN_MAX_CODE);
    max_b    = (ep == '0) ? 32'(EP0_MAX_BANKS) : 32'(EPN_MAX_BANKS);
    legal    = (32'(code) <= max_c) && (banks != 2'd0) &&
               (32'(banks) <= max_b) && (end_sum <= (AW+1)'(RAM_BYTES));
  end
endmodule

// File: rtl/bufwin_low_end.sv
module bufwin_low_end #(
  parameter int NUM_EP = 4,
  parameter int AW     = 15,
  parameter int EP_W   = 2
) (
  input  logic [EP_W-1:0]             ep,
  input  logic [NUM_EP-1:0]           alloc,
  input  logic [NUM_EP-1:0][AW-1:0]   base,
  input  logic [NUM_EP-1:0][AW-1:0]   size,
  output logic [AW-1:0]               low_end
);
  // End of the highest allocated window strictly below ep.
  always_comb begin
    low_end = '0;
    for (int k = 0; k < NUM_EP; k++) begin
      if ((EP_W'(k) < ep) && alloc[k]) low_end = base[k] + size[k];
    end
  end
endmodule

// File: rtl/bufwin_overlap.sv
module bufwin_overlap #(
  parameter int NUM_EP = 4,
  parameter int AW     = 15
) (
  input  logic [NUM_EP-1:0]           alloc,
  input  logic [NUM_EP-1:0][AW-1:0]   base,
  input  logic [NUM_EP-1:0][AW-1:0]   size,
  output logic [NUM_EP-1:0]           hit
);
  logic [NUM_EP-1:0][AW:0] lim;
  logic [NUM_EP-1:0]       live;

  always_comb begin
    for (int i = 0; i < NUM_EP; i++) begin
      lim[i]  = {1'b0, base[i]} + {1'b0, size[i]};
      live[i] = alloc[i] && (size[i] != '0);
    end
    hit = '0;
    for (int i = 0; i < NUM_EP; i++) begin
      for (int j = 0; j < NUM_EP; j++) begin
        if ((i != j) && live[i] && live[j] &&
            ({1'b0, base[i]} < lim[j]) && ({1'b0, base[j]} < lim[i]))
          hit[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/bufwin_alloc.sv
module bufwin_alloc #(
  parameter int NUM_EP        = 4,
  parameter int RAM_BYTES     = 4096,
  parameter int EP0_MAX_CODE  = 3,
  parameter int EPN_MAX_CODE  = 7,
  parameter int EP0_MAX_BANKS = 1,
  parameter int EPN_MAX_BANKS = 3,
  localparam int EP_W = (NUM_EP > 1) ? $clog2(NUM_EP) : 1,
  localparam int AW   = $clog2(NUM_EP * 3 * (8 << EPN_MAX_CODE) + RAM_BYTES + 1)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [EP_W-1:0]              wr_ep,
  input  logic [bufwin_pkg::CFG_W-1:0] wr_data,
  output logic [NUM_EP*AW-1:0]         ep_base,
  output logic [NUM_EP*AW-1:0]         ep_size,
  output logic [NUM_EP-1:0]            ep_alloc,
  output logic [NUM_EP-1:0]            ep_enable,
  output logic [NUM_EP-1:0]            ep_cfg_ok,
  output logic [NUM_EP-1:0]            ep_overlap
);
  import bufwin_pkg::*;

  cfg_word_t                 w;
  logic [NUM_EP-1:0][AW-1:0] base_q, base_d, size_q, size_d;
  logic [NUM_EP-1:0]         alloc_q, alloc_d, en_q, en_d, ok_q, ok_d, ovl_q, ovl_d;
  logic [AW-1:0]             low_end, new_size;
  logic                      new_legal;

  assign w = cfg_word_t'(wr_data);

  bufwin_low_end #(.NUM_EP(NUM_EP), .AW(AW), .EP_W(EP_W)) low_i (
    .ep(wr_ep), .alloc(alloc_q), .base(base_q), .size(size_q), .low_end(low_end)
  );

  bufwin_size_calc #(
    .AW(AW), .EP_W(EP_W), .RAM_BYTES(RAM_BYTES),
    .EP0_MAX_CODE(EP0_MAX_CODE), .EPN_MAX_CODE(EPN_MAX_CODE),
    .EP0_MAX_BANKS(EP0_MAX_BANKS), .EPN_MAX_BANKS(EPN_MAX_BANKS)
  ) size_i (
    .ep(wr_ep), .code(w.code), .banks(w.banks), .start(low_end),
    .win_size(new_size), .legal(new_legal)
  );

  // Next state: the written endpoint and its upper neighbour only.
  always_comb begin
    base_d  = base_q;
    size_d  = size_q;
    alloc_d = alloc_q;
    en_d    = en_q;
    ok_d    = ok_q;
    if (wr_en) begin
      for (int i = 0; i < NUM_EP; i++) begin
        if (EP_W'(i) == wr_ep) begin
          en_d[i] = w.enable;
          if (w.alloc && !alloc_q[i]) begin
            alloc_d[i] = 1'b1;
            base_d[i]  = low_end;
            size_d[i]  = new_size;
            ok_d[i]    = new_legal;
          end else if (!w.alloc && alloc_q[i]) begin
            alloc_d[i] = 1'b0;
            base_d[i]  = '0;
            size_d[i]  = '0;
            ok_d[i]    = 1'b0;
          end
        end
      end
      for (int i = 1; i < NUM_EP; i++) begin
        if ((EP_W'(i - 1) == wr_ep) && alloc_q[i]) begin
          if (w.alloc && !alloc_q[i-1])
            base_d[i] = low_end + new_size;
          else if (!w.alloc && alloc_q[i-1])
            base_d[i] = low_end;
        end
      end
    end
  end

  bufwin_overlap #(.NUM_EP(NUM_EP), .AW(AW)) ovl_i (
    .alloc(alloc_d), .base(base_d), .size(size_d), .hit(ovl_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      size_q  <= '0;
      alloc_q <= '0;
      en_q    <= '0;
      ok_q    <= '0;
      ovl_q   <= '0;
    end else begin
      base_q  <= base_d;
      size_q  <= size_d;
      alloc_q <= alloc_d;
      en_q    <= en_d;
      ok_q    <= ok_d;
      ovl_q   <= ovl_d;
    end
  end

  assign ep_base    = base_q;
  assign ep_size    = size_q;
  assign ep_alloc   = alloc_q;
  assign ep_enable  = en_q;
  assign ep_cfg_ok  = ok_q;
  assign ep_overlap = ovl_q;
endmodule

// File: rtl/bufwin_alloc_chk.sv
module bufwin_alloc_chk #(
  parameter int NUM_EP = 4,
  parameter int AW     = 15,
  parameter int EP_W   = 2
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         wr_en,
  input logic [EP_W-1:0]              wr_ep,
  input logic [bufwin_pkg::CFG_W-1:0] wr_data,
  input logic [NUM_EP*AW-1:0]         ep_base,
  input logic [NUM_EP*AW-1:0]         ep_size,
  input logic [NUM_EP-1:0]            ep_alloc,
  input logic [NUM_EP-1:0]            ep_enable,
  input logic [NUM_EP-1:0]            ep_cfg_ok,
  input logic [NUM_EP-1:0]            ep_overlap
);
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(ep_base) && $stable(ep_size) && $stable(ep_alloc) && $stable(ep_cfg_ok))); // R2

  AST_OVERLAP_PAIRS: assert property (@(posedge clk) disable iff (rst)
    $countones(ep_overlap) != 1); // R9

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    AST_FAR_UNMOVED: assert property (@(posedge clk) disable iff (rst)
      (wr_en && ((int'(wr_ep) > i) || (int'(wr_ep) + 2 <= i))) |=> $stable(ep_base[i*AW +: AW])); // R7

    AST_FREE_EMPTIES: assert property (@(posedge clk) disable iff (rst)
      (wr_en && (wr_ep == EP_W'(i)) && !wr_data[6]) |=>
        (!ep_alloc[i] && (ep_size[i*AW +: AW] == '0) && !ep_cfg_ok[i])); // R5

    AST_HELD_WINDOW: assert property (@(posedge clk) disable iff (rst)
      (wr_en && (wr_ep == EP_W'(i)) && wr_data[6] && ep_alloc[i]) |=>
        (ep_alloc[i] && $stable(ep_base[i*AW +: AW]) && $stable(ep_size[i*AW +: AW]))); // R4

    AST_ENABLE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
      (wr_en && (wr_ep == EP_W'(i))) |=> (ep_enable[i] == $past(wr_data[5]))); // R4

    AST_OK_NEEDS_ALLOC: assert property (@(posedge clk) disable iff (rst)
      ep_cfg_ok[i] |-> ep_alloc[i]); // R8
  end
endmodule

bind bufwin_alloc bufwin_alloc_chk #(.NUM_EP(NUM_EP), .AW(AW), .EP_W(EP_W)) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ep(wr_ep), .wr_data(wr_data),
  .ep_base(ep_base), .ep_size(ep_size), .ep_alloc(ep_alloc), .ep_enable(ep_enable),
  .ep_cfg_ok(ep_cfg_ok), .ep_overlap(ep_overlap)
);

// File: tb/bufwin_alloc_tb_top.sv
`timescale 1ns/1ps
module bufwin_alloc_tb_top;
  localparam int NUM_EP = 4;
  localparam int EP_W   = 2;
  localparam int AW     = $clog2(NUM_EP * 3 * (8 << 7) + 4096 + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [EP_W-1:0] wr_ep = '0;
  logic [6:0] wr_data = '0;
  logic [NUM_EP*AW-1:0] ep_base, ep_size;
  logic [NUM_EP-1:0] ep_alloc, ep_enable, ep_cfg_ok, ep_overlap;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bufwin_alloc dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ep(wr_ep), .wr_data(wr_data),
    .ep_base(ep_base), .ep_size(ep_size), .ep_alloc(ep_alloc), .ep_enable(ep_enable),
    .ep_cfg_ok(ep_cfg_ok), .ep_overlap(ep_overlap)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int base_of(input int ep);
    return int'(ep_base[ep*AW +: AW]);
  endfunction

  function automatic int size_of(input int ep);
    return int'(ep_size[ep*AW +: AW]);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // One write; results are sampled at the following falling edge.
  task automatic wr(input int ep, input bit alloc, input bit en, input int banks, input int code);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_ep   = EP_W'(ep);
    wr_data = {alloc, en, 2'(banks), 3'(code)};
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1", "alloc", int'(ep_alloc), 0);
    check("R1", "enable", int'(ep_enable), 0);
    check("R1", "cfg_ok", int'(ep_cfg_ok), 0);
    check("R1", "overlap", int'(ep_overlap), 0);
    check("R1", "base flat nonzero", int'(ep_base != '0), 0);
    check("R1", "size flat nonzero", int'(ep_size != '0), 0);
  endtask

  task automatic t_pack();
    wr(0, 1, 1, 1, 3);
    check("R2", "ep0 size", size_of(0), 64);
    check("R3", "ep0 base", base_of(0), 0);
    wr(1, 1, 1, 2, 4);
    check("R2", "ep1 size (128x2)", size_of(1), 256);
    check("R3", "ep1 base", base_of(1), 64);
    wr(2, 1, 1, 1, 5);
    check("R3", "ep2 base", base_of(2), 320);
    wr(3, 1, 1, 1, 6);
    check("R3", "ep3 base", base_of(3), 576);
    check("R2", "ep3 size", size_of(3), 512);
    check("R8", "all legal", int'(ep_cfg_ok), 15);
    check("R9", "no overlap", int'(ep_overlap), 0);
    repeat (3) @(negedge clk);
    check("R2", "idle hold ep3 base", base_of(3), 576);
  endtask

  task automatic t_disable_keeps();
    wr(2, 1, 0, 3, 0);
    check("R4", "ep2 enable", int'(ep_enable[2]), 0);
    check("R4", "ep2 still allocated", int'(ep_alloc[2]), 1);
    check("R4", "ep2 base", base_of(2), 320);
    check("R4", "ep2 size ignores new fields", size_of(2), 256);
  endtask

  task automatic t_free_slide();
    wr(1, 0, 0, 0, 0);
    check("R5", "ep1 alloc", int'(ep_alloc[1]), 0);
    check("R5", "ep1 base", base_of(1), 0);
    check("R5", "ep1 size", size_of(1), 0);
    check("R5", "ep1 cfg_ok", int'(ep_cfg_ok[1]), 0);
    check("R5", "ep2 slid down", base_of(2), 64);
    check("R7", "ep3 unmoved", base_of(3), 576);
    check("R7", "ep0 unmoved", base_of(0), 0);
  endtask

  task automatic t_grow_conflict();
    wr(1, 1, 1, 2, 6);
    check("R3", "ep1 base", base_of(1), 64);
    check("R2", "ep1 size", size_of(1), 1024);
    check("R6", "ep2 pushed up", base_of(2), 1088);
    check("R7", "ep3 unmoved", base_of(3), 576);
    check("R7", "ep0 unmoved", base_of(0), 0);
    check("R9", "overlap ep1+ep3, ep2 touches only", int'(ep_overlap), 4'b1010);
  endtask

  task automatic t_free_unalloc();
    do_reset();
    wr(0, 1, 1, 1, 3);
    wr(2, 1, 1, 1, 4);
    check("R3", "ep2 skips gap", base_of(2), 64);
    wr(1, 0, 1, 1, 4);
    check("R10", "ep1 stays free", int'(ep_alloc[1]), 0);
    check("R10", "ep1 size", size_of(1), 0);
    check("R10", "ep2 base", base_of(2), 64);
    check("R10", "ep2 size", size_of(2), 128);
    wr(0, 0, 0, 0, 0);
    check("R5", "ep0 freed", int'(ep_alloc[0]), 0);
    check("R7", "ep2 not neighbour, unmoved", base_of(2), 64);
  endtask

  task automatic t_cfg_ok();
    do_reset();
    wr(0, 1, 1, 1, 4);
    check("R8", "ep0 code over limit ok", int'(ep_cfg_ok[0]), 0);
    check("R8", "ep0 still allocated", int'(ep_alloc[0]), 1);
    check("R8", "ep0 size", size_of(0), 128);
    wr(0, 0, 0, 0, 0);
    wr(0, 1, 1, 2, 3);
    check("R8", "ep0 banks over limit ok", int'(ep_cfg_ok[0]), 0);
    wr(0, 0, 0, 0, 0);
    wr(0, 1, 1, 1, 3);
    check("R8", "ep0 legal ok", int'(ep_cfg_ok[0]), 1);
    wr(1, 1, 1, 3, 7);
    check("R8", "ep1 3072 fits ok", int'(ep_cfg_ok[1]), 1);
    check("R3", "ep1 base", base_of(1), 64);
    wr(2, 1, 1, 1, 7);
    check("R8", "ep2 beyond RAM ok", int'(ep_cfg_ok[2]), 0);
    check("R3", "ep2 base", base_of(2), 3136);
    wr(3, 1, 1, 0, 0);
    check("R8", "ep3 zero banks ok", int'(ep_cfg_ok[3]), 0);
    check("R2", "ep3 zero size", size_of(3), 0);
    check("R9", "no overlap", int'(ep_overlap), 0);
    check("R7", "ep0 base stable", base_of(0), 0);
  endtask

  initial begin
    t_reset();
    t_pack();
    t_disable_keeps();
    t_free_slide();
    t_grow_conflict();
    t_free_unalloc();
    t_cfg_ok();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule